// File: doc/BRIEF.md
# Extended Register State Enable and Instruction Gating

This block keeps the architectural enable mask for three saveable register components: the legacy floating-point stack (mask bit 0), the 128-bit SIMD registers with their control/status word (mask bit 1), and the upper halves of the 256-bit vector registers (mask bit 2). Three control-register bits come in as plain level inputs. These are the extended-state OS enable (control bit 18), the SIMD floating-point fault enable (control bit 10) and the legacy SIMD enable (control bit 9).

One request per cycle arrives from decode as an operation code. For each request the block returns a verdict one cycle later. The verdict says to execute, to raise invalid-opcode, to raise general-protection (error code 0), or, for a pending SIMD floating-point fault, to report that fault. Mask writes are validated against the component dependency rules and are committed only when legal. Mask reads return the current mask. A constant capability vector lists the components the hardware supports.

Top module: `xstate_gate`

## Requirements
- R1: After reset the mask reads 0x1, `rsp_vld` is 0, `rsp_verdict` is EXEC (0) and `rsp_rd_data` is 0.
- R2: A mask write (op 0) or mask read (op 1) with `ctl_xsave_en` low returns invalid-opcode (1) and leaves the mask unchanged.
- R3: A mask write whose bits [2:1] are 10b returns general-protection (2) and leaves the mask unchanged.
- R4: A mask write with bit 0 clear, or with any bit above bit 2 set, returns general-protection (2) and leaves the mask unchanged.
- R5: A legal mask write with `ctl_xsave_en` high returns EXEC (0), and the new value is on `mask_q` one cycle after the request. Writing 0x7 enables all three components. The mask changes only through such writes.
- R6: A mask read with `ctl_xsave_en` high returns EXEC and puts the current mask on `rsp_rd_data`. Every other response carries 0 there.
- R7: A wide-vector request (op 2) returns EXEC only when `ctl_xsave_en` is high and mask bits 2 and 1 are both 1. Otherwise it returns invalid-opcode. `ctl_sse_en` has no effect on it.
- R8: A legacy 128-bit SIMD request (op 3) returns EXEC when `ctl_sse_en` is high and invalid-opcode when it is low.
- R9: A SIMD floating-point fault request (op 4) returns report-fault (3) when `ctl_simdfp_en` is high and invalid-opcode when it is low.
- R10: `cap_vec` reads 0x7: bit 0 legacy floating-point, bit 1 128-bit SIMD, bit 2 upper-vector state.
- R11: `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high.
- R12: Op codes 5 to 7 return invalid-opcode and leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_xsave_en | input | 1 | Control bit 18: OS enables extended state and mask access |
| ctl_simdfp_en | input | 1 | Control bit 10: SIMD floating-point faults may be reported |
| ctl_sse_en | input | 1 | Control bit 9: legacy SIMD instructions enabled |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 write mask, 1 read mask, 2 wide vector, 3 legacy SIMD, 4 SIMD FP fault |
| req_wdata | input | 64 | Value for a mask write |
| rsp_vld | output | 1 | Response valid (one cycle after request) |
| rsp_verdict | output | 2 | 0 execute, 1 invalid-opcode, 2 general-protection, 3 report SIMD FP fault |
| rsp_rd_data | output | 64 | Mask value for a successful read, else 0 |
| mask_q | output | 64 | Current feature-enable mask |
| cap_vec | output | 64 | Supported component vector |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any request. They also assume the control bits and request fields are stable around the sampling edge, so that the verdict can be judged against the values present in the request cycle. The bench drives all inputs on the falling edge and returns `req_vld` to low between requests. This keeps every response tied to one request. The random write values are drawn mostly from the 3-bit space so that the legal, dependency-violating and bit-0-clear cases all appear often. A high bit is set now and then to exercise the out-of-range rule.

// File: rtl/xstate_pkg.sv
// Package: shared widths, component bit positions, op codes and verdicts
// for the extended-state gate. Assumes a mask of at most 64 bits.
package xstate_pkg;
    localparam int MASK_W   = 64;
    localparam int OP_W     = 3;
    localparam int BIT_X87  = 0;
    localparam int BIT_SSE  = 1;
    localparam int BIT_UPR  = 2;

    localparam logic [OP_W-1:0] OP_MASK_WR = 3'd0;
    localparam logic [OP_W-1:0] OP_MASK_RD = 3'd1;
    localparam logic [OP_W-1:0] OP_WIDE    = 3'd2;
    localparam logic [OP_W-1:0] OP_LEGACY  = 3'd3;
    localparam logic [OP_W-1:0] OP_FPFLT   = 3'd4;

    typedef enum logic [1:0] {
        VD_EXEC = 2'd0,
        VD_UD   = 2'd1,
        VD_GP   = 2'd2,
        VD_XF   = 2'd3
    } verdict_e;
endpackage

// File: rtl/xstate_cap.sv
// Capability vector: sets one bit per supported component, low bits first.
// Assumes NUM_COMP <= W.
module xstate_cap #(
    parameter int W        = 64,
    parameter int NUM_COMP = 3
) (
    output logic [W-1:0] cap
);
    // one generate slot per mask bit: supported when below NUM_COMP
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NUM_COMP) begin : g_on
            assign cap[i] = 1'b1;
        end else begin : g_off
            assign cap[i] = 1'b0;
        end
    end
endmodule

// File: rtl/xstate_mask_reg.sv
// Feature-enable mask register with write validation.
// Checks the OS-enable bit first, then the dependency and range rules.
// Commits only legal writes. Assumes at most one write per cycle.
module xstate_mask_reg
    import xstate_pkg::*;
#(
    parameter int W = MASK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         xsave_on,
    input  logic [W-1:0] supported,
    output verdict_e     wr_verdict,
    output logic [W-1:0] mask
);
    localparam logic [W-1:0] RESET_VAL = W'(1) << BIT_X87;

    logic bad_range;
    logic bad_base;
    logic bad_dep;
    logic legal;

    // rule evaluation for the candidate value
    always_comb begin
        bad_range = |(wr_data & ~supported);
        bad_base  = !wr_data[BIT_X87];
        bad_dep   = wr_data[BIT_UPR] && !wr_data[BIT_SSE];
        legal     = !(bad_range || bad_base || bad_dep);
    end

    // verdict for a write: OS enable first, then legality
    always_comb begin
        if (!xsave_on)   wr_verdict = VD_UD;
        else if (!legal) wr_verdict = VD_GP;
        else             wr_verdict = VD_EXEC;
    end

    // mask storage: load only on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= RESET_VAL;
        else if (wr_req && xsave_on && legal)
            mask <= wr_data;
    end
endmodule

// File: rtl/xstate_class_gate.sv
// Combinational verdict for instruction classes that are not mask accesses.
// Op codes outside the known set map to invalid-opcode.
module xstate_class_gate
    import xstate_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            xsave_on,
    input  logic            simdfp_on,
    input  logic            sse_on,
    input  logic [1:0]      upr_sse_en,
    output verdict_e        verdict
);
    // per-class enable decision
    always_comb begin
        unique case (op)
            OP_WIDE:   verdict = (xsave_on && (upr_sse_en == 2'b11)) ? VD_EXEC : VD_UD;
            OP_LEGACY: verdict = sse_on    ? VD_EXEC : VD_UD;
            OP_FPFLT:  verdict = simdfp_on ? VD_XF   : VD_UD;
            default:   verdict = VD_UD;
        endcase
    end
endmodule

// File: rtl/xstate_gate.sv
// Top: joins mask register, class gate and capability vector, and registers
// one response per request. Assumes one request per cycle; responses appear
// one cycle after the request.
module xstate_gate
    import xstate_pkg::*;
#(
    parameter int NUM_COMP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_xsave_en,
    input  logic              ctl_simdfp_en,
    input  logic              ctl_sse_en,
    input  logic              req_vld,
    input  logic [OP_W-1:0]   req_op,
    input  logic [MASK_W-1:0] req_wdata,
    output logic              rsp_vld,
    output logic [1:0]        rsp_verdict,
    output logic [MASK_W-1:0] rsp_rd_data,
    output logic [MASK_W-1:0] mask_q,
    output logic [MASK_W-1:0] cap_vec
);
    verdict_e wr_vd;
    verdict_e cls_vd;
    verdict_e nxt_vd;
    logic     is_wr;
    logic     is_rd;

    xstate_cap #(.W(MASK_W), .NUM_COMP(NUM_COMP)) u_cap (
        .cap (cap_vec)
    );

    // write strobe decode
    always_comb begin
        is_wr = req_vld && (req_op == OP_MASK_WR);
        is_rd = req_vld && (req_op == OP_MASK_RD);
    end

    xstate_mask_reg #(.W(MASK_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (is_wr),
        .wr_data    (req_wdata),
        .xsave_on   (ctl_xsave_en),
        .supported  (cap_vec),
        .wr_verdict (wr_vd),
        .mask       (mask_q)
    );

    xstate_class_gate u_gate (
        .op         (req_op),
        .xsave_on   (ctl_xsave_en),
        .simdfp_on  (ctl_simdfp_en),
        .sse_on     (ctl_sse_en),
        .upr_sse_en (mask_q[BIT_UPR:BIT_SSE]),
        .verdict    (cls_vd)
    );

    // verdict selection across mask access and instruction classes
    always_comb begin
        if (req_op == OP_MASK_WR)      nxt_vd = wr_vd;
        else if (req_op == OP_MASK_RD) nxt_vd = ctl_xsave_en ? VD_EXEC : VD_UD;
        else                           nxt_vd = cls_vd;
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld     <= 1'b0;
            rsp_verdict <= VD_EXEC;
            rsp_rd_data <= '0;
        end else begin
            rsp_vld     <= req_vld;
            rsp_verdict <= req_vld ? nxt_vd : VD_EXEC;
            rsp_rd_data <= (is_rd && ctl_xsave_en) ? mask_q : '0;
        end
    end
endmodule

// File: rtl/xstate_gate_chk.sv
// Checker for xstate_gate: temporal properties over ports and mask state.
// Assumes reset is asserted on the first edge.
module xstate_gate_chk
    import xstate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_xsave_en,
    input logic              ctl_simdfp_en,
    input logic              ctl_sse_en,
    input logic              req_vld,
    input logic [OP_W-1:0]   req_op,
    input logic              rsp_vld,
    input logic [1:0]        rsp_verdict,
    input logic [MASK_W-1:0] mask_q
);
    AST_MASK_NOACCESS: assert property (@(posedge clk) disable iff (!rst_n) req_vld && (req_op <= OP_MASK_RD) && !ctl_xsave_en |=> rsp_verdict == VD_UD && $stable(mask_q)); // R2
    AST_MASK_DEP: assert property (@(posedge clk) disable iff (!rst_n) mask_q[BIT_UPR:BIT_SSE] != 2'b10); // R3
    AST_MASK_BASE: assert property (@(posedge clk) disable iff (!rst_n) mask_q[BIT_X87] && (mask_q[MASK_W-1:3] == '0)); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(req_vld && req_op == OP_MASK_WR) |=> $stable(mask_q)); // R5
    AST_WIDE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) req_vld && req_op == OP_WIDE && !ctl_xsave_en |=> rsp_verdict == VD_UD); // R7
    AST_LEGACY_OK: assert property (@(posedge clk) disable iff (!rst_n) req_vld && req_op == OP_LEGACY && ctl_sse_en |=> rsp_verdict == VD_EXEC); // R8
    AST_FPFLT_UD: assert property (@(posedge clk) disable iff (!rst_n) req_vld && req_op == OP_FPFLT && !ctl_simdfp_en |=> rsp_verdict == VD_UD); // R9
    AST_RSP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> rsp_vld); // R11
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> !rsp_vld); // R11
endmodule

bind xstate_gate xstate_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_xsave_en  (ctl_xsave_en),
    .ctl_simdfp_en (ctl_simdfp_en),
    .ctl_sse_en    (ctl_sse_en),
    .req_vld       (req_vld),
    .req_op        (req_op),
    .rsp_vld       (rsp_vld),
    .rsp_verdict   (rsp_verdict),
    .mask_q        (mask_q)
);

// File: tb/tb_xstate_gate.sv
module tb_xstate_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c18 = 1'b0, c10 = 1'b0, c9 = 1'b0;
    logic        req_vld = 1'b0;
    logic [2:0]  req_op = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_vld;
    logic [1:0]  rsp_verdict;
    logic [63:0] rsp_rd_data, mask_q, cap_vec;

    int checks = 0;
    int errors = 0;
    logic [63:0] model_mask = 64'h1;

    always #4 clk = ~clk;

    xstate_gate dut (
        .clk(clk), .rst_n(rst_n), .ctl_xsave_en(c18), .ctl_simdfp_en(c10),
        .ctl_sse_en(c9), .req_vld(req_vld), .req_op(req_op), .req_wdata(req_wdata),
        .rsp_vld(rsp_vld), .rsp_verdict(rsp_verdict), .rsp_rd_data(rsp_rd_data),
        .mask_q(mask_q), .cap_vec(cap_vec)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit wr_legal(input logic [63:0] d);
        return d[0] && (d[63:3] == '0) && !(d[2] && !d[1]);
    endfunction

    function automatic logic [1:0] exp_vd(input logic [2:0] op, input logic [63:0] d,
                                          input logic x, input logic f, input logic s,
                                          input logic [63:0] m);
        case (op)
            3'd0: return !x ? 2'd1 : (wr_legal(d) ? 2'd0 : 2'd2);
            3'd1: return x ? 2'd0 : 2'd1;
            3'd2: return (x && m[2] && m[1]) ? 2'd0 : 2'd1;
            3'd3: return s ? 2'd0 : 2'd1;
            3'd4: return f ? 2'd3 : 2'd1;
            default: return 2'd1;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [63:0] d, input logic x);
        if (op <= 3'd1 && !x) return "R2";
        case (op)
            3'd0: begin
                if (d[2:1] == 2'b10 && d[0] && d[63:3] == '0) return "R3";
                if (!wr_legal(d)) return "R4";
                return "R5";
            end
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R12";
        endcase
    endfunction

    // one request: drive at falling edge, sample at the next falling edge
    task automatic do_req(input logic [2:0] op, input logic [63:0] d,
                          input logic x, input logic f, input logic s);
        logic [1:0]  ev;
        logic [63:0] erd;
        string       t;
        ev  = exp_vd(op, d, x, f, s, model_mask);
        erd = (op == 3'd1 && x) ? model_mask : 64'h0;
        t   = tag_of(op, d, x);
        if (op == 3'd0 && x && wr_legal(d)) model_mask = d;
        req_vld = 1'b1; req_op = op; req_wdata = d; c18 = x; c10 = f; c9 = s;
        @(negedge clk);
        req_vld = 1'b0;
        check(rsp_vld === 1'b1, "R11 rsp_vld", 64'(rsp_vld), 64'h1);
        check(rsp_verdict === ev, t, 64'(rsp_verdict), 64'(ev));
        check(mask_q === model_mask, t, mask_q, model_mask);
        check(rsp_rd_data === erd, "R6 rd_data", rsp_rd_data, erd);
        @(negedge clk);
        check(rsp_vld === 1'b0, "R11 idle", 64'(rsp_vld), 64'h0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mask_q === 64'h1, "R1 mask", mask_q, 64'h1);
        check(rsp_vld === 1'b0, "R1 rsp_vld", 64'(rsp_vld), 64'h0);
        check(rsp_verdict === 2'd0, "R1 verdict", 64'(rsp_verdict), 64'h0);
        check(rsp_rd_data === 64'h0, "R1 rd_data", rsp_rd_data, 64'h0);
        // R10 capability
        check(cap_vec === 64'h7, "R10 cap", cap_vec, 64'h7);
        // directed corners
        do_req(3'd0, 64'h7, 1'b0, 1'b0, 1'b0);              // R2 write while disabled
        do_req(3'd1, 64'h0, 1'b0, 1'b0, 1'b0);              // R2 read while disabled
        do_req(3'd2, 64'h0, 1'b1, 1'b0, 1'b1);              // R7 mask still 0x1
        do_req(3'd0, 64'h5, 1'b1, 1'b0, 1'b0);              // R3 bits[2:1]=10
        do_req(3'd0, 64'h6, 1'b1, 1'b0, 1'b0);              // R4 bit0 clear
        do_req(3'd0, 64'h8000_0000_0000_0007, 1'b1, 1'b0, 1'b0); // R4 high bit
        do_req(3'd0, 64'h7, 1'b1, 1'b0, 1'b0);              // R5 enable all
        do_req(3'd1, 64'h0, 1'b1, 1'b0, 1'b0);              // R6 read back 0x7
        do_req(3'd2, 64'h0, 1'b1, 1'b0, 1'b0);              // R7 exec, c9 low ignored
        do_req(3'd2, 64'h0, 1'b0, 1'b0, 1'b1);              // R7 UD without c18
        do_req(3'd3, 64'h0, 1'b0, 1'b0, 1'b0);              // R8 UD
        do_req(3'd3, 64'h0, 1'b0, 1'b0, 1'b1);              // R8 exec
        do_req(3'd4, 64'h0, 1'b1, 1'b1, 1'b0);              // R9 report
        do_req(3'd4, 64'h0, 1'b1, 1'b0, 1'b1);              // R9 UD
        do_req(3'd6, 64'h3, 1'b1, 1'b1, 1'b1);              // R12 reserved op
        do_req(3'd0, 64'h3, 1'b1, 1'b0, 1'b0);              // R5 drop upper
        do_req(3'd2, 64'h0, 1'b1, 1'b1, 1'b1);              // R7 UD, bit2 clear
        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] d;
            d = 64'($urandom % 8);
            if (($urandom % 10) == 0) d[3 + ($urandom % 61)] = 1'b1;
            do_req(3'($urandom % 8), d, 1'($urandom % 4 != 0),
                   1'($urandom), 1'($urandom));
        end
        check(cap_vec === 64'h7, "R10 cap end", cap_vec, 64'h7);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule